// File: doc/BRIEF.md
# SMBus Configuration Register Slave

This block is a two-wire serial slave that gives a host controller access to a small bank of 8-bit configuration registers. It accepts four transaction types: a single indexed byte write, a single indexed byte read, a counted block write and a counted block read. The first byte after the device address is a command code, and its most significant bit chooses the access type. For indexed access, the lower seven bits give the register offset. For block access, the transfer always starts at register 0 and moves upward.

Both bus lines are oversampled in the system clock domain. SCL and SDA each pass through a two-flop synchroniser, and the start, stop and clock edges are detected from the synchronised levels. The data line is driven open-drain: the single output `sda_oe` pulls the line low when it is high. The register contents are presented in parallel to the clock-control logic around the block. One register carries a strap field that is captured from external pins during reset and cannot be written. A second register is wholly read-only and holds a fixed identification value.

Top module: `smbcfg_slave`

## Requirements
- R1: The slave acknowledges only the address byte whose upper seven bits are 7'b1101001, so the write address is D2h and the read address is D3h. On any other address it does not acknowledge, and it neither acknowledges nor writes any byte until the next start condition.
- R2: A write transaction whose command byte has bit 7 = 1 stores the following data byte into the register at offset command[6:0]. The slave acknowledges the command byte and the data byte.
- R3: After a byte-access command (bit 7 = 1), a repeated start and D3h, the slave returns the register at the commanded offset, MSB first.
- R4: A write transaction whose command byte has bit 7 = 0 is a block write. The next byte is a count N, and the data bytes that follow go to registers 0, 1, 2 and upward. The first N data bytes are acknowledged. Data bytes beyond N are not acknowledged and are discarded.
- R5: After a block command (00h), a repeated start and D3h, the slave first sends the count 08h (the number of registers), then registers 0, 1, 2 and upward. It continues while the master acknowledges and stops sending after a master NACK.
- R6: Reset loads the defaults reg0=02h, reg1=81h, reg2=10h, reg3=00h, reg4=FFh, reg5=7Fh, reg6=00h and reg7=C3h. Bits [3:0] of reg2 then take the value of `strap_in` as sampled during reset, and `sda_oe` is 0.
- R7: Writes to read-only bits are discarded. These are all of reg7 and bits [3:0] of reg2. The writable bits of those registers still take the written value.
- R8: Offsets from 8 to 127 read as 00h. Writes to them are acknowledged and change no register.
- R9: `cfg_q[8*i+7:8*i]` shows register i and follows every accepted write.
- R10: `sda_oe` changes only while the synchronised SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset; the strap pins are sampled while it is high |
| scl_in | input | 1 | Serial clock line level |
| sda_in | input | 1 | Serial data line level |
| sda_oe | output | 1 | Pull the data line low when 1 |
| strap_in | input | 4 | Strap pins captured into reg2[3:0] during reset |
| cfg_q | output | 64 | All register contents, register i at bits 8*i+7:8*i |

## Verification
A wrong bit counter or a wrong phase register shows up within one byte time. It appears as an acknowledge in the wrong bit slot, or as read data shifted by one position, which the master checks on every ninth clock. A pointer or byte-count error does not show at once. It appears only later, when a block read or an indexed readback returns a byte from the wrong register, or when a byte beyond the count is acknowledged. For this reason every write sweep is followed by a full readback and a compare of `cfg_q` against the model. A lost ignore state shows in the next mismatched transaction, as a stray acknowledge or as a changed register.

// File: rtl/smbcfg_pkg.sv
package smbcfg_pkg;

  typedef enum logic [3:0] {
    PH_IDLE,
    PH_RX,
    PH_RX_ACK,
    PH_ACK_HOLD,
    PH_TX,
    PH_TX_ACK,
    PH_TX_MACK,
    PH_TX_NEXT,
    PH_IGNORE
  } phase_e;

  typedef enum logic [1:0] {
    RL_ADDR,
    RL_CMD,
    RL_CNT,
    RL_DATA
  } role_e;

endpackage

// File: rtl/smbcfg_line_sync.sv
module smbcfg_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  localparam int MSB = STAGES - 1;

  logic [MSB:0] scl_pipe;
  logic [MSB:0] sda_pipe;
  logic         scl_prev;
  logic         sda_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_prev <= 1'b1;
      sda_prev <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[MSB-1:0], scl_in};
      sda_pipe <= {sda_pipe[MSB-1:0], sda_in};
      scl_prev <= scl_pipe[MSB];
      sda_prev <= sda_pipe[MSB];
    end
  end

  assign scl_lvl   = scl_pipe[MSB];
  assign sda_lvl   = sda_pipe[MSB];
  assign scl_rise  = scl_pipe[MSB] & ~scl_prev;
  assign scl_fall  = ~scl_pipe[MSB] & scl_prev;
  assign start_det = scl_pipe[MSB] & scl_prev & sda_prev & ~sda_pipe[MSB];
  assign stop_det  = scl_pipe[MSB] & scl_prev & ~sda_prev & sda_pipe[MSB];

endmodule

// File: rtl/smbcfg_regbank.sv
module smbcfg_regbank #(
  parameter int                    NUM_REGS  = 8,
  parameter int                    STRAP_W   = 4,
  parameter int                    STRAP_REG = 2,
  parameter logic [NUM_REGS*8-1:0] DEFAULTS  = 64'hC3_00_7F_FF_00_10_81_02,
  parameter logic [NUM_REGS*8-1:0] RO_MASK   = 64'hFF_00_00_00_00_00_00_00
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [STRAP_W-1:0]    strap_in,
  input  logic                  wr_en,
  input  logic [6:0]            wr_addr,
  input  logic [7:0]            wr_data,
  input  logic [6:0]            rd_addr,
  output logic [7:0]            rd_data,
  output logic [NUM_REGS*8-1:0] cfg_q
);

  localparam int         IDX_W      = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
  localparam logic [6:0] NREG7      = 7'(NUM_REGS);
  localparam logic [7:0] STRAP_MASK = 8'((1 << STRAP_W) - 1);

  logic [NUM_REGS-1:0][7:0] regs;
  logic [7:0]               strap_byte;

  assign strap_byte = 8'(strap_in);

  function automatic logic [7:0] ro_of(input int idx);
    logic [7:0] m;
    m = RO_MASK[idx*8 +: 8];
    if (idx == STRAP_REG) m = m | STRAP_MASK;
    return m;
  endfunction

  function automatic logic [7:0] rst_of(input int idx, input logic [7:0] sb);
    logic [7:0] v;
    v = DEFAULTS[idx*8 +: 8];
    if (idx == STRAP_REG) v = (v & ~STRAP_MASK) | (sb & STRAP_MASK);
    return v;
  endfunction

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    localparam logic [7:0] RO = ro_of(i);

    always_ff @(posedge clk) begin
      if (rst) begin
        regs[i] <= rst_of(i, strap_byte);
      end else if (wr_en && (wr_addr == 7'(i))) begin
        regs[i] <= (regs[i] & RO) | (wr_data & ~RO);
      end
    end

    AST_RO_STABLE: assert property (@(posedge clk) disable iff (rst)
      $stable(regs[i] & RO)); // R7
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= 8'h00;
    end else if (rd_addr < NREG7) begin
      rd_data <= regs[rd_addr[IDX_W-1:0]];
    end else begin
      rd_data <= 8'h00;
    end
  end

  assign cfg_q = regs;

  AST_OOR_NOWR: assert property (@(posedge clk) disable iff (rst)
    (wr_en && (wr_addr >= NREG7)) |=> $stable(regs)); // R8

endmodule

// File: rtl/smbcfg_proto.sv
module smbcfg_proto
  import smbcfg_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'b1101001,
  parameter int         NUM_REGS = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       scl_lvl,
  input  logic       sda_lvl,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       start_det,
  input  logic       stop_det,
  input  logic [7:0] rd_data,
  output logic [6:0] ptr,
  output logic       wr_en,
  output logic [6:0] wr_addr,
  output logic [7:0] wr_data,
  output logic       sda_oe
);

  localparam logic [7:0] CNT_BYTE = 8'(NUM_REGS);

  phase_e     phase;
  role_e      role;
  logic [2:0] bitcnt;
  logic [7:0] shreg;
  logic [7:0] txreg;
  logic [7:0] wr_left;
  logic       ack_q;
  logic       rd_mode;
  logic       is_byte;
  logic       cnt_pend;
  logic [7:0] rx_byte;
  logic [7:0] tx_src;
  logic [6:0] ptr_inc;

  assign rx_byte = {shreg[6:0], sda_lvl};
  assign tx_src  = cnt_pend ? CNT_BYTE : rd_data;
  assign ptr_inc = (ptr == 7'h7F) ? ptr : ptr + 7'd1;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase    <= PH_IDLE;
      role     <= RL_ADDR;
      bitcnt   <= 3'd0;
      shreg    <= 8'h00;
      txreg    <= 8'h00;
      wr_left  <= 8'h00;
      ack_q    <= 1'b0;
      rd_mode  <= 1'b0;
      is_byte  <= 1'b0;
      cnt_pend <= 1'b0;
      ptr      <= 7'd0;
      wr_en    <= 1'b0;
      wr_addr  <= 7'd0;
      wr_data  <= 8'h00;
      sda_oe   <= 1'b0;
    end else begin
      wr_en <= 1'b0;
      if (start_det) begin
        phase  <= PH_RX;
        role   <= RL_ADDR;
        bitcnt <= 3'd0;
        sda_oe <= 1'b0;
      end else if (stop_det) begin
        phase  <= PH_IDLE;
        sda_oe <= 1'b0;
      end else begin
        unique case (phase)
          PH_RX: begin
            if (scl_rise) begin
              shreg  <= rx_byte;
              bitcnt <= bitcnt + 3'd1;
              if (bitcnt == 3'd7) begin
                unique case (role)
                  RL_ADDR: begin
                    if (rx_byte[7:1] == DEV_ADDR) begin
                      ack_q   <= 1'b1;
                      rd_mode <= rx_byte[0];
                      role    <= rx_byte[0] ? RL_DATA : RL_CMD;
                      phase   <= PH_RX_ACK;
                    end else begin
                      phase <= PH_IGNORE;
                    end
                  end
                  RL_CMD: begin
                    is_byte  <= rx_byte[7];
                    ptr      <= rx_byte[7] ? rx_byte[6:0] : 7'd0;
                    cnt_pend <= ~rx_byte[7];
                    wr_left  <= 8'h00;
                    role     <= rx_byte[7] ? RL_DATA : RL_CNT;
                    ack_q    <= 1'b1;
                    phase    <= PH_RX_ACK;
                  end
                  RL_CNT: begin
                    wr_left <= rx_byte;
                    role    <= RL_DATA;
                    ack_q   <= 1'b1;
                    phase   <= PH_RX_ACK;
                  end
                  RL_DATA: begin
                    phase <= PH_RX_ACK;
                    if (is_byte || (wr_left != 8'h00)) begin
                      wr_en   <= 1'b1;
                      wr_addr <= ptr;
                      wr_data <= rx_byte;
                      ack_q   <= 1'b1;
                      ptr     <= ptr_inc;
                      if (!is_byte) wr_left <= wr_left - 8'd1;
                    end else begin
                      ack_q <= 1'b0;
                    end
                  end
                  default: phase <= PH_IGNORE;
                endcase
              end
            end
          end
          PH_RX_ACK: begin
            if (scl_fall) begin
              sda_oe <= ack_q;
              phase  <= PH_ACK_HOLD;
            end
          end
          PH_ACK_HOLD: begin
            if (scl_fall) begin
              bitcnt <= 3'd0;
              if (rd_mode) begin
                txreg  <= tx_src;
                sda_oe <= ~tx_src[7];
                phase  <= PH_TX;
              end else begin
                sda_oe <= 1'b0;
                phase  <= PH_RX;
              end
            end
          end
          PH_TX: begin
            if (scl_rise) begin
              bitcnt <= bitcnt + 3'd1;
              if (bitcnt == 3'd7) phase <= PH_TX_ACK;
            end else if (scl_fall) begin
              txreg  <= {txreg[6:0], 1'b0};
              sda_oe <= ~txreg[6];
            end
          end
          PH_TX_ACK: begin
            if (scl_fall) begin
              sda_oe <= 1'b0;
              phase  <= PH_TX_MACK;
            end
          end
          PH_TX_MACK: begin
            if (scl_rise) begin
              if (!sda_lvl) begin
                if (cnt_pend) cnt_pend <= 1'b0;
                else          ptr      <= ptr_inc;
                phase <= PH_TX_NEXT;
              end else begin
                phase <= PH_IGNORE;
              end
            end
          end
          PH_TX_NEXT: begin
            if (scl_fall) begin
              txreg  <= tx_src;
              sda_oe <= ~tx_src[7];
              bitcnt <= 3'd0;
              phase  <= PH_TX;
            end
          end
          default: ;
        endcase
      end
    end
  end

  AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
    !$stable(sda_oe) |-> !scl_lvl); // R10

  AST_IGNORE_QUIET: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_IGNORE) |-> (!sda_oe && !wr_en)); // R1

  AST_TX_ONLY_READ: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_TX) |-> rd_mode); // R3

  AST_WR_ONLY_ACKED: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (phase == PH_RX_ACK) && ack_q); // R4

endmodule

// File: rtl/smbcfg_slave.sv
module smbcfg_slave #(
  parameter logic [6:0]            DEV_ADDR  = 7'b1101001,
  parameter int                    NUM_REGS  = 8,
  parameter int                    STRAP_W   = 4,
  parameter int                    STRAP_REG = 2,
  parameter int                    SYNC_STG  = 2,
  parameter logic [NUM_REGS*8-1:0] DEFAULTS  = 64'hC3_00_7F_FF_00_10_81_02,
  parameter logic [NUM_REGS*8-1:0] RO_MASK   = 64'hFF_00_00_00_00_00_00_00
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  scl_in,
  input  logic                  sda_in,
  output logic                  sda_oe,
  input  logic [STRAP_W-1:0]    strap_in,
  output logic [NUM_REGS*8-1:0] cfg_q
);

  logic       scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;
  logic [6:0] ptr;
  logic       wr_en;
  logic [6:0] wr_addr;
  logic [7:0] wr_data;
  logic [7:0] rd_data;

  smbcfg_line_sync #(
    .STAGES(SYNC_STG)
  ) u_sync (
    .clk      (clk),
    .rst      (rst),
    .scl_in   (scl_in),
    .sda_in   (sda_in),
    .scl_lvl  (scl_lvl),
    .sda_lvl  (sda_lvl),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_det(start_det),
    .stop_det (stop_det)
  );

  smbcfg_proto #(
    .DEV_ADDR(DEV_ADDR),
    .NUM_REGS(NUM_REGS)
  ) u_proto (
    .clk      (clk),
    .rst      (rst),
    .scl_lvl  (scl_lvl),
    .sda_lvl  (sda_lvl),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_det(start_det),
    .stop_det (stop_det),
    .rd_data  (rd_data),
    .ptr      (ptr),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .sda_oe   (sda_oe)
  );

  smbcfg_regbank #(
    .NUM_REGS (NUM_REGS),
    .STRAP_W  (STRAP_W),
    .STRAP_REG(STRAP_REG),
    .DEFAULTS (DEFAULTS),
    .RO_MASK  (RO_MASK)
  ) u_regs (
    .clk     (clk),
    .rst     (rst),
    .strap_in(strap_in),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_addr (ptr),
    .rd_data (rd_data),
    .cfg_q   (cfg_q)
  );

endmodule

// File: tb/sim_smbcfg_slave.sv
module sim_smbcfg_slave;

  localparam int Q = 5;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        scl = 1'b1;
  logic        m_low = 1'b0;
  logic        sda_oe;
  logic [3:0]  strap = 4'b1011;
  logic [63:0] cfg_q;
  logic        sda_line;

  int tests = 0;
  int fails = 0;
  bit done  = 0;

  logic [7:0] model [0:7];
  logic [7:0] blk_buf [0:15];
  logic       blk_ack [0:15];
  logic [7:0] rd_buf  [0:15];

  assign sda_line = ~(m_low | sda_oe);

  always #10 clk = ~clk;

  smbcfg_slave u0 (
    .clk     (clk),
    .rst     (rst),
    .scl_in  (scl),
    .sda_in  (sda_line),
    .sda_oe  (sda_oe),
    .strap_in(strap),
    .cfg_q   (cfg_q)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] ro_bits(input int off);
    if (off == 7) return 8'hFF;
    if (off == 2) return 8'h0F;
    return 8'h00;
  endfunction

  task automatic model_wr(input int off, input logic [7:0] d);
    if (off < 8) model[off] = (model[off] & ro_bits(off)) | (d & ~ro_bits(off));
  endtask

  function automatic logic [7:0] model_rd(input int off);
    if (off < 8) return model[off];
    return 8'h00;
  endfunction

  function automatic logic [63:0] model_packed();
    logic [63:0] v;
    for (int k = 0; k < 8; k++) v[k*8 +: 8] = model[k];
    return v;
  endfunction

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    m_low = 1'b0; wq();
    scl = 1'b1; wq(); wq();
    m_low = 1'b1; wq(); wq();
    scl = 1'b0; wq();
  endtask

  task automatic bus_stop();
    m_low = 1'b1; wq();
    scl = 1'b1; wq(); wq();
    m_low = 1'b0; wq(); wq();
  endtask

  task automatic bit_cycle(input logic drive, output logic seen);
    m_low = ~drive; wq();
    scl = 1'b1; wq();
    seen = sda_line; wq();
    scl = 1'b0; wq();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic s;
    for (int k = 7; k >= 0; k--) bit_cycle(b[k], s);
    bit_cycle(1'b1, s);
    ack = ~s;
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] b);
    logic s;
    for (int k = 7; k >= 0; k--) begin
      bit_cycle(1'b1, s);
      b[k] = s;
    end
    bit_cycle(~give_ack, s);
  endtask

  task automatic byte_write(input int off, input logic [7:0] d, output logic all_ack);
    logic a0, a1, a2;
    bus_start();
    send_byte(8'hD2, a0);
    send_byte({1'b1, 7'(off)}, a1);
    send_byte(d, a2);
    bus_stop();
    all_ack = a0 & a1 & a2;
  endtask

  task automatic byte_read(input int off, output logic [7:0] d, output logic all_ack);
    logic a0, a1, a2;
    bus_start();
    send_byte(8'hD2, a0);
    send_byte({1'b1, 7'(off)}, a1);
    bus_start();
    send_byte(8'hD3, a2);
    recv_byte(1'b0, d);
    bus_stop();
    all_ack = a0 & a1 & a2;
  endtask

  task automatic block_write(input logic [7:0] cnt, input int n, output logic hdr_ack);
    logic a0, a1, a2;
    bus_start();
    send_byte(8'hD2, a0);
    send_byte(8'h00, a1);
    send_byte(cnt, a2);
    for (int k = 0; k < n; k++) send_byte(blk_buf[k], blk_ack[k]);
    bus_stop();
    hdr_ack = a0 & a1 & a2;
  endtask

  task automatic block_read(input int n, output logic [7:0] cnt, output logic hdr_ack);
    logic a0, a1, a2;
    bus_start();
    send_byte(8'hD2, a0);
    send_byte(8'h00, a1);
    bus_start();
    send_byte(8'hD3, a2);
    recv_byte(1'b1, cnt);
    for (int k = 0; k < n; k++) recv_byte(k != n - 1, rd_buf[k]);
    bus_stop();
    hdr_ack = a0 & a1 & a2;
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic       ok;
    logic [7:0] d;
    logic [7:0] cnt;

    model[0] = 8'h02; model[1] = 8'h81; model[2] = 8'h1B; model[3] = 8'h00;
    model[4] = 8'hFF; model[5] = 8'h7F; model[6] = 8'h00; model[7] = 8'hC3;

    repeat (5) @(negedge clk);
    rst = 1'b0;
    strap = 4'b0100;
    repeat (3) @(negedge clk);

    chk("R6 reset cfg_q", cfg_q, model_packed());
    chk("R6 reset sda_oe", {63'd0, sda_oe}, 64'd0);

    // R3 R8: indexed read sweep over defaults and out-of-range offsets
    for (int off = 0; off < 16; off++) begin
      byte_read(off, d, ok);
      chk($sformatf("R3 read ack off %0d", off), {63'd0, ok}, 64'd1);
      chk($sformatf("R3 R8 read data off %0d", off), {56'd0, d}, {56'd0, model_rd(off)});
    end
    byte_read(127, d, ok);
    chk("R8 read off 127", {56'd0, d}, 64'd0);

    // R2 R7 R8: indexed write sweep, then readback
    for (int off = 0; off < 12; off++) begin
      d = 8'((off * 37) ^ 8'h3C);
      byte_write(off, d, ok);
      model_wr(off, d);
      chk($sformatf("R2 R8 write ack off %0d", off), {63'd0, ok}, 64'd1);
    end
    byte_write(127, 8'h55, ok);
    chk("R8 write ack off 127", {63'd0, ok}, 64'd1);
    for (int off = 0; off < 12; off++) begin
      byte_read(off, d, ok);
      chk($sformatf("R2 R7 readback off %0d", off), {56'd0, d}, {56'd0, model_rd(off)});
    end
    chk("R9 cfg_q after indexed writes", cfg_q, model_packed());

    // R4 R5: block write/read pattern sweep
    for (int p = 0; p < 4; p++) begin
      for (int k = 0; k < 8; k++) blk_buf[k] = 8'(p * 53 + k * 29 + 7);
      block_write(8'd8, 8, ok);
      chk($sformatf("R4 block hdr ack p%0d", p), {63'd0, ok}, 64'd1);
      for (int k = 0; k < 8; k++) begin
        model_wr(k, blk_buf[k]);
        chk($sformatf("R4 block data ack p%0d k%0d", p, k), {63'd0, blk_ack[k]}, 64'd1);
      end
      block_read(8, cnt, ok);
      chk($sformatf("R5 block count p%0d", p), {56'd0, cnt}, 64'h08);
      for (int k = 0; k < 8; k++)
        chk($sformatf("R5 R7 block read p%0d k%0d", p, k), {56'd0, rd_buf[k]}, {56'd0, model[k]});
      chk($sformatf("R9 cfg_q after block p%0d", p), cfg_q, model_packed());
    end

    // R4: bytes beyond the count are not acknowledged and discarded
    for (int k = 0; k < 5; k++) blk_buf[k] = 8'hE0 + 8'(k);
    block_write(8'd3, 5, ok);
    for (int k = 0; k < 5; k++) begin
      chk($sformatf("R4 count limit ack k%0d", k), {63'd0, blk_ack[k]}, {63'd0, (k < 3)});
      if (k < 3) model_wr(k, blk_buf[k]);
    end
    block_read(8, cnt, ok);
    for (int k = 0; k < 8; k++)
      chk($sformatf("R4 count limit contents k%0d", k), {56'd0, rd_buf[k]}, {56'd0, model[k]});

    // R5: early stop after two data bytes, then an indexed read still works
    block_read(2, cnt, ok);
    chk("R5 early stop byte0", {56'd0, rd_buf[0]}, {56'd0, model[0]});
    chk("R5 early stop byte1", {56'd0, rd_buf[1]}, {56'd0, model[1]});
    byte_read(5, d, ok);
    chk("R5 read after early stop", {56'd0, d}, {56'd0, model[5]});

    // R1: foreign addresses are ignored until the next start
    begin
      logic a0, a1, a2;
      bus_start();
      send_byte(8'hD4, a0);
      send_byte(8'h81, a1);
      send_byte(8'h99, a2);
      bus_stop();
      chk("R1 foreign addr nack", {63'd0, a0}, 64'd0);
      chk("R1 ignored cmd nack", {63'd0, a1}, 64'd0);
      chk("R1 ignored data nack", {63'd0, a2}, 64'd0);
      bus_start();
      send_byte(8'h52, a0);
      send_byte(8'h00, a1);
      bus_stop();
      chk("R1 addr 52h nack", {63'd0, a0}, 64'd0);
    end
    byte_read(1, d, ok);
    chk("R1 reg1 unchanged", {56'd0, d}, {56'd0, model[1]});
    chk("R1 R9 cfg_q unchanged", cfg_q, model_packed());

    done = 1;
    summary();
    $finish;
  end

endmodule